// File: doc/BRIEF.md
# Dual-Tone Keypad Frequency Decoder

This block recognises telephone keypad tones after the analog front end has split them into two bands and squared them up. It takes one full-swing square wave for the low band and one for the high band. For each band it measures the period of the square wave by counting cycles of its own clock between successive rising edges. It compares that count against a window around each of the four standard frequencies of that band. A band is declared to hold a tone only after several consecutive periods have all landed in the same window. This averaging rejects short bursts and the wandering periods that speech produces, while still allowing small frequency errors.

While both bands hold a tone, the block raises an early-steering flag and presents a 4-bit key code. The flag falls as soon as either band loses its tone. Guard-time validation and output latching are left to the logic downstream. A power-down input clears all detection state and holds both outputs low. Window bounds and timeouts are derived at elaboration from the clock frequency parameter `CLK_HZ`, which defaults to 3579545. The run length `RUN_LEN` defaults to 4.

Top module: `dtmf_pair_decoder`

## Requirements
- R1: While reset is asserted and after reset is released, `est` is 0 and `key_code` is 4'b0000 until a tone pair has been validated.
- R2: A low-band period is measured as the number of clock cycles between two successive rising edges of `tone_lo`. A square wave within ±1.5% of 697, 770, 852 or 941 Hz is accepted as that tone.
- R3: The high band measures `tone_hi` the same way. A square wave within ±1.5% of 1209, 1336, 1477 or 1633 Hz is accepted as that tone.
- R4: A square wave that is more than 3.5% away from every nominal frequency of its band is never accepted, so `est` stays 0.
- R5: A band becomes valid only after `RUN_LEN` consecutive measured periods fall in the window of the same frequency. A burst that is too short, or periods that alternate between two windows, never make the band valid.
- R6: `est` is 1 only while both bands are valid. One band alone keeps it at 0.
- R7: A measured period outside the window of the tone being held drops `est` on the following cycles, without waiting for a timeout. If there is no rising edge for 1.5 times the longest accepted period of the band's lowest tone, the band also becomes invalid.
- R8: The key code depends on row (low tone) and column (high tone). Digits 1 to 9 give 0001 to 1001, 0 gives 1010, * gives 1011, # gives 1100, A gives 1101, B gives 1110, C gives 1111 and D gives 0000. The rows are 1 2 3 A / 4 5 6 B / 7 8 9 C / * 0 # D from 697 Hz up, and the columns run from 1209 Hz up. While `est` is 0, `key_code` is 0000.
- R9: While `est` stays high, `key_code` does not change.
- R10: With `pwr_dn` high, `est` and `key_code` are 0 from the next clock edge on, and all detection state is cleared. After release, a tone pair that is still present needs a full new validation run before `est` rises.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Reference clock at `CLK_HZ` |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| pwr_dn | input | 1 | Power-down: clears detection, forces outputs low |
| tone_lo | input | 1 | Limited square wave from the low-band path |
| tone_hi | input | 1 | Limited square wave from the high-band path |
| est | output | 1 | Early-steering flag: both bands hold a valid tone |
| key_code | output | 4 | Code of the detected key, 0 while `est` is low |

## Verification
All sixteen keys are driven with seeded random frequency offsets within ±1.2%, plus directed offsets of ±1.4%. These cases confirm that each window accepts its own tone and that the row and column map to the right code. Tone pairs in which one band is shifted by 4.5–6% exercise the rejection edge, and a lone low tone shows that a single band never steers. Bursts shorter than the run length, and a low band that alternates between 697 and 770 Hz, separate true averaging from a simple in-window test. A mid-tone switch of the high band to an out-of-band frequency is checked well before the silence timeout could act, which tells immediate loss apart from loss by timeout. Power-down is asserted during a held pair and then released, which shows both the one-cycle clearing and the full revalidation that follows.

// File: rtl/dtmf_pkg.sv
package dtmf_pkg;

  localparam int unsigned TONES_PER_BAND = 4;

  // Nominal frequency of tone idx in band grp (0 = low band, 1 = high band)
  function automatic int unsigned tone_hz(input int unsigned grp, input int unsigned idx);
    int unsigned hz;
    case (idx)
      0:       hz = (grp == 0) ? 697 : 1209;
      1:       hz = (grp == 0) ? 770 : 1336;
      2:       hz = (grp == 0) ? 852 : 1477;
      default: hz = (grp == 0) ? 941 : 1633;
    endcase
    return hz;
  endfunction

  // Shortest accepted period: frequency about 2.5% above nominal
  function automatic int unsigned per_min(input int unsigned clk_hz, input int unsigned hz);
    longint unsigned num;
    num = 64'(clk_hz) * 64'd40;
    return 32'(num / (64'(hz) * 64'd41));
  endfunction

  // Longest accepted period: frequency about 2.5% below nominal
  function automatic int unsigned per_max(input int unsigned clk_hz, input int unsigned hz);
    longint unsigned num;
    num = 64'(clk_hz) * 64'd40;
    return 32'(num / (64'(hz) * 64'd39));
  endfunction

  // Row/column to 4-bit key code; column 3 gives A..D, where D wraps to 0
  function automatic logic [3:0] key_code(input logic [1:0] row, input logic [1:0] col);
    logic [3:0] k;
    if (col == 2'd3)      k = 4'd13 + {2'b00, row};
    else if (row == 2'd3) k = (col == 2'd0) ? 4'd11 : ((col == 2'd1) ? 4'd10 : 4'd12);
    else                  k = {row, 2'b00} - {2'b00, row} + {2'b00, col} + 4'd1;
    return k;
  endfunction

endpackage

// File: rtl/dtmf_period_meter.sv
module dtmf_period_meter #(
  parameter int unsigned CNT_W   = 14,
  parameter int unsigned TIMEOUT = 1000
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pd,
  input  logic             tone_in,
  output logic             meas_v,
  output logic [CNT_W-1:0] meas,
  output logic             stale
);
  localparam logic [CNT_W-1:0] TO_C = CNT_W'(TIMEOUT);

  logic [1:0]       sync_q, sync_d;
  logic             prev_q, prev_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             armed_q, armed_d;
  logic             mv_q, mv_d;
  logic [CNT_W-1:0] m_q, m_d;
  logic             rise;

  assign rise   = sync_q[1] & ~prev_q;
  assign stale  = (cnt_q >= TO_C);
  assign meas_v = mv_q;
  assign meas   = m_q;

  always_comb begin
    sync_d  = {sync_q[0], tone_in};
    prev_d  = sync_q[1];
    cnt_d   = cnt_q;
    armed_d = armed_q;
    mv_d    = 1'b0;
    m_d     = m_q;
    if (pd) begin
      sync_d  = 2'b00;
      prev_d  = 1'b0;
      cnt_d   = '0;
      armed_d = 1'b0;
    end else if (rise) begin
      // the first edge after silence only arms the meter
      mv_d    = armed_q;
      m_d     = cnt_q;
      cnt_d   = {{(CNT_W-1){1'b0}}, 1'b1};
      armed_d = 1'b1;
    end else if (!stale) begin
      cnt_d   = cnt_q + 1'b1;
    end else begin
      armed_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q  <= 2'b00;
      prev_q  <= 1'b0;
      cnt_q   <= '0;
      armed_q <= 1'b0;
      mv_q    <= 1'b0;
      m_q     <= '0;
    end else begin
      sync_q  <= sync_d;
      prev_q  <= prev_d;
      cnt_q   <= cnt_d;
      armed_q <= armed_d;
      mv_q    <= mv_d;
      m_q     <= m_d;
    end
  end

endmodule

// File: rtl/dtmf_tone_class.sv
module dtmf_tone_class #(
  parameter int unsigned GRP     = 0,
  parameter int unsigned CLK_HZ  = 3579545,
  parameter int unsigned CNT_W   = 14,
  parameter int unsigned RUN_LEN = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pd,
  input  logic             meas_v,
  input  logic [CNT_W-1:0] meas,
  input  logic             stale,
  output logic             valid,
  output logic [1:0]       idx
);
  localparam int unsigned NT = dtmf_pkg::TONES_PER_BAND;
  localparam int unsigned RW = $clog2(RUN_LEN + 1);
  localparam logic [RW-1:0] RUN_C = RW'(RUN_LEN);

  logic [NT-1:0]  hit;
  logic [1:0]     hit_idx;
  logic [RW-1:0]  run_q, run_d;
  logic [1:0]     idx_q, idx_d;

  for (genvar i = 0; i < NT; i++) begin : g_win
    localparam int unsigned NOM = dtmf_pkg::tone_hz(GRP, i);
    localparam logic [CNT_W-1:0] LO = CNT_W'(dtmf_pkg::per_min(CLK_HZ, NOM));
    localparam logic [CNT_W-1:0] HI = CNT_W'(dtmf_pkg::per_max(CLK_HZ, NOM));
    assign hit[i] = (meas >= LO) && (meas <= HI);
  end

  // windows are disjoint, so at most one bit of hit is set
  always_comb begin
    hit_idx = 2'd0;
    for (int i = 0; i < NT; i++) begin
      if (hit[i]) hit_idx = 2'(i);
    end
  end

  always_comb begin
    run_d = run_q;
    idx_d = idx_q;
    if (pd || stale) begin
      run_d = '0;
    end else if (meas_v) begin
      if (|hit) begin
        if ((run_q != '0) && (hit_idx == idx_q)) begin
          run_d = (run_q == RUN_C) ? run_q : run_q + 1'b1;
        end else begin
          run_d = {{(RW-1){1'b0}}, 1'b1};
          idx_d = hit_idx;
        end
      end else begin
        run_d = '0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q <= '0;
      idx_q <= 2'd0;
    end else begin
      run_q <= run_d;
      idx_q <= idx_d;
    end
  end

  assign valid = (run_q == RUN_C);
  assign idx   = idx_q;

endmodule

// File: rtl/dtmf_pair_decoder.sv
module dtmf_pair_decoder #(
  parameter int unsigned CLK_HZ  = 3579545,
  parameter int unsigned RUN_LEN = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       pwr_dn,
  input  logic       tone_lo,
  input  logic       tone_hi,
  output logic       est,
  output logic [3:0] key_code
);
  localparam int unsigned TO_LO = dtmf_pkg::per_max(CLK_HZ, dtmf_pkg::tone_hz(0, 0)) * 3 / 2;
  localparam int unsigned TO_HI = dtmf_pkg::per_max(CLK_HZ, dtmf_pkg::tone_hz(1, 0)) * 3 / 2;
  localparam int unsigned CNT_W = $clog2(TO_LO + 1);

  logic [1:0] rst_pipe;
  logic       srst_n;
  logic [1:0] tin;
  logic [1:0] grp_valid;
  logic [1:0] grp_idx [2];
  logic       lo_valid, hi_valid;
  logic       est_q, est_d;
  logic [3:0] code_q, code_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign srst_n = rst_pipe[1];

  assign tin = {tone_hi, tone_lo};

  for (genvar g = 0; g < 2; g++) begin : g_band
    localparam int unsigned TO = (g == 0) ? TO_LO : TO_HI;
    logic             mv;
    logic [CNT_W-1:0] mp;
    logic             stl;

    dtmf_period_meter #(.CNT_W(CNT_W), .TIMEOUT(TO)) meter_i (
      .clk(clk), .rst_n(srst_n), .pd(pwr_dn), .tone_in(tin[g]),
      .meas_v(mv), .meas(mp), .stale(stl)
    );

    dtmf_tone_class #(.GRP(g), .CLK_HZ(CLK_HZ), .CNT_W(CNT_W), .RUN_LEN(RUN_LEN)) class_i (
      .clk(clk), .rst_n(srst_n), .pd(pwr_dn), .meas_v(mv), .meas(mp), .stale(stl),
      .valid(grp_valid[g]), .idx(grp_idx[g])
    );
  end

  assign lo_valid = grp_valid[0];
  assign hi_valid = grp_valid[1];

  always_comb begin
    est_d  = lo_valid & hi_valid & ~pwr_dn;
    code_d = est_d ? dtmf_pkg::key_code(grp_idx[0], grp_idx[1]) : 4'h0;
  end

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) begin
      est_q  <= 1'b0;
      code_q <= 4'h0;
    end else begin
      est_q  <= est_d;
      code_q <= code_d;
    end
  end

  assign est      = est_q;
  assign key_code = code_q;

endmodule

// File: rtl/dtmf_pair_decoder_chk.sv
module dtmf_pair_decoder_chk (
  input logic       clk,
  input logic       srst_n,
  input logic       pwr_dn,
  input logic       lo_valid,
  input logic       hi_valid,
  input logic       est,
  input logic [3:0] key_code
);

  // R10
  pd_quiet_chk: assert property (@(posedge clk) disable iff (!srst_n)
    pwr_dn |=> (!est && key_code == 4'h0));

  // R8
  idle_code_chk: assert property (@(posedge clk) disable iff (!srst_n)
    !est |-> key_code == 4'h0);

  // R9
  code_hold_chk: assert property (@(posedge clk) disable iff (!srst_n)
    (est && $past(est)) |-> $stable(key_code));

  // R6
  pair_needed_chk: assert property (@(posedge clk) disable iff (!srst_n)
    est |-> $past(lo_valid && hi_valid));

  // R7
  lo_loss_chk: assert property (@(posedge clk) disable iff (!srst_n)
    $fell(lo_valid) |=> !est);

  // R7
  hi_loss_chk: assert property (@(posedge clk) disable iff (!srst_n)
    $fell(hi_valid) |=> !est);

endmodule

bind dtmf_pair_decoder dtmf_pair_decoder_chk chk_i (
  .clk(clk), .srst_n(srst_n), .pwr_dn(pwr_dn), .lo_valid(lo_valid),
  .hi_valid(hi_valid), .est(est), .key_code(key_code)
);

// File: tb/dtmf_pair_decoder_tb_top.sv
module dtmf_pair_decoder_tb_top;
  localparam int CLKF = 500000;
  localparam int RUN  = 4;
  localparam int QUIET = 1300;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       pwr_dn;
  logic       tone_lo;
  logic       tone_hi;
  logic       est;
  logic [3:0] key_code;

  int lo_per = 0;
  int lo_alt = 0;
  int hi_per = 0;
  int n_chk  = 0;
  int n_fail = 0;
  int est_hi_cnt = 0;
  bit done = 0;

  int LOW_HZ [4] = '{697, 770, 852, 941};
  int HIGH_HZ[4] = '{1209, 1336, 1477, 1633};

  always #2 clk = ~clk;

  dtmf_pair_decoder #(.CLK_HZ(CLKF), .RUN_LEN(RUN)) dut_i (
    .clk(clk), .rst_n(rst_n), .pwr_dn(pwr_dn), .tone_lo(tone_lo),
    .tone_hi(tone_hi), .est(est), .key_code(key_code)
  );

  always @(negedge clk) if (est === 1'b1) est_hi_cnt++;

  // low-band square wave; optionally alternates between two periods
  initial begin
    tone_lo = 1'b0;
    forever begin
      if (lo_per == 0) begin
        tone_lo = 1'b0;
        @(negedge clk);
      end else begin
        int p;
        p = lo_per;
        tone_lo = 1'b1;
        repeat (p / 2) @(negedge clk);
        tone_lo = 1'b0;
        repeat (p - p / 2) @(negedge clk);
        if (lo_alt != 0) begin
          int t;
          t = lo_per; lo_per = lo_alt; lo_alt = t;
        end
      end
    end
  end

  initial begin
    tone_hi = 1'b0;
    forever begin
      if (hi_per == 0) begin
        tone_hi = 1'b0;
        @(negedge clk);
      end else begin
        int p;
        p = hi_per;
        tone_hi = 1'b1;
        repeat (p / 2) @(negedge clk);
        tone_hi = 1'b0;
        repeat (p - p / 2) @(negedge clk);
      end
    end
  end

  function automatic int per(int f, int dev_permil);
    int den;
    den = f * (1000 + dev_permil);
    return (CLKF * 1000 + den / 2) / den;
  endfunction

  function automatic logic [3:0] exp_code(int r, int c);
    string rows [4] = '{"123A", "456B", "789C", "*0#D"};
    byte ch;
    ch = rows[r][c];
    if (ch >= "1" && ch <= "9") return 4'(ch - "0");
    case (ch)
      "0": return 4'd10;
      "*": return 4'd11;
      "#": return 4'd12;
      "A": return 4'd13;
      "B": return 4'd14;
      "C": return 4'd15;
      default: return 4'd0;
    endcase
  endfunction

  task automatic chk(bit ok, string req, string what, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic wait_neg(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic set_tones(int lp, int hp);
    lo_alt = 0;
    lo_per = lp;
    hi_per = hp;
  endtask

  task automatic quiet_check(string tag);
    set_tones(0, 0);
    wait_neg(QUIET);
    chk(est == 1'b0, "R7", {tag, " est after silence"}, int'(est), 0);
    chk(key_code == 4'h0, "R8", {tag, " code after silence"}, int'(key_code), 0);
  endtask

  task automatic run_pair(int r, int c, int dlo, int dhi, bit exp_ok, string req);
    int lp, hp;
    logic [3:0] ec;
    lp = per(LOW_HZ[r], dlo);
    hp = per(HIGH_HZ[c], dhi);
    ec = exp_ok ? exp_code(r, c) : 4'h0;
    set_tones(lp, hp);
    wait_neg(6 * lp + 40);
    chk(est == exp_ok, req, "est with pair", int'(est), int'(exp_ok));
    chk(key_code == ec, "R8", "key code", int'(key_code), int'(ec));
    if (exp_ok) begin
      wait_neg(150);
      chk(key_code == ec && est, "R9", "code held", int'(key_code), int'(ec));
    end
    quiet_check(req);
  endtask

  initial begin
    int s;
    s = est_hi_cnt;
    rst_n  = 1'b0;
    pwr_dn = 1'b0;
    s = int'($urandom(32'h0d7f_0511));
    wait_neg(5);
    // R1: outputs idle in reset
    chk(est == 1'b0, "R1", "est in reset", int'(est), 0);
    chk(key_code == 4'h0, "R1", "code in reset", int'(key_code), 0);
    rst_n = 1'b1;
    wait_neg(20);
    chk(est == 1'b0 && key_code == 4'h0, "R1", "outputs after reset", int'(est), 0);

    // R2/R3/R8: every key with a small random offset per band
    for (int r = 0; r < 4; r++) begin
      for (int c = 0; c < 4; c++) begin
        int dl, dh;
        dl = int'($urandom_range(24)) - 12;
        dh = int'($urandom_range(24)) - 12;
        run_pair(r, c, dl, dh, 1'b1, "R2/R3");
      end
    end

    // R2/R3: directed offsets near the acceptance limit
    run_pair(0, 3, 14, -14, 1'b1, "R2/R3");
    run_pair(3, 0, -14, 14, 1'b1, "R2/R3");

    // R4: one band shifted well outside tolerance
    for (int k = 0; k < 4; k++) begin
      int r, c, mag, dl, dh;
      r   = int'($urandom_range(3));
      c   = int'($urandom_range(3));
      mag = 45 + int'($urandom_range(15));
      if ($urandom_range(1) == 1) mag = -mag;
      dl = (k % 2 == 0) ? mag : 0;
      dh = (k % 2 == 0) ? 0 : mag;
      run_pair(r, c, dl, dh, 1'b0, "R4");
    end

    // R6: a lone low tone never steers
    set_tones(per(770, 0), 0);
    wait_neg(6 * per(770, 0) + 40);
    chk(est == 1'b0, "R6", "single band est", int'(est), 0);
    quiet_check("R6");

    // R5: low band alternates between two valid windows
    s = est_hi_cnt;
    hi_per = per(1336, 0);
    lo_alt = per(770, 0);
    lo_per = per(697, 0);
    wait_neg(12 * per(697, 0));
    chk(est_hi_cnt == s, "R5", "alternating periods est cycles", est_hi_cnt - s, 0);
    quiet_check("R5");

    // R5: burst of only two measurable periods
    s = est_hi_cnt;
    set_tones(per(852, 0), per(1477, 0));
    wait_neg(2 * per(852, 0) + per(852, 0) / 2);
    set_tones(0, 0);
    wait_neg(QUIET);
    chk(est_hi_cnt == s, "R5", "short burst est cycles", est_hi_cnt - s, 0);

    // R7: high band jumps out of band while low band continues
    set_tones(per(770, 0), per(1336, 0));
    wait_neg(6 * per(770, 0) + 40);
    chk(est == 1'b1, "R6", "pair before jump", int'(est), 1);
    hi_per = per(1100, 0);
    wait_neg(per(1336, 0) + per(1100, 0) + 20);
    chk(est == 1'b0, "R7", "est after bad period", int'(est), 0);
    quiet_check("R7");

    // R10: power-down during a held pair, then release
    set_tones(per(941, 0), per(1209, 0));
    wait_neg(6 * per(941, 0) + 40);
    chk(est == 1'b1 && key_code == exp_code(3, 0), "R10", "pair before power-down",
        int'(key_code), int'(exp_code(3, 0)));
    pwr_dn = 1'b1;
    wait_neg(1);
    chk(est == 1'b0 && key_code == 4'h0, "R10", "outputs one cycle into power-down",
        int'(est), 0);
    wait_neg(800);
    chk(est == 1'b0 && key_code == 4'h0, "R10", "outputs held in power-down", int'(est), 0);
    pwr_dn = 1'b0;
    wait_neg(2 * per(941, 0));
    chk(est == 1'b0, "R10", "no early steering after release", int'(est), 0);
    wait_neg(5 * per(941, 0));
    chk(est == 1'b1 && key_code == exp_code(3, 0), "R10", "revalidated after release",
        int'(key_code), int'(exp_code(3, 0)));
    quiet_check("R10");

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (195000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog (all requirements) actual=running expected=finished");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

endmodule